// File: doc/BRIEF.md
# Tagged Operand Matching Unit

This unit is the operand-pairing stage of a tagged-token dataflow pipeline. Each incoming token names an activation frame, an instruction, an input side (port) and a data value. Code is shared by all activations: the instruction number selects an entry in a code store that gives the operation, a slot offset inside the frame, and up to two destinations. The token tag is the frame base, so several activations of the same code can be in flight at once without their operands ever pairing with each other.

A two-input operation waits in its frame slot, at frame base plus offset. The first arriving operand is written there and a presence flag is raised. The second operand finds the flag set. It clears the flag and fires the operation with the stored value. A one-input operation fires as soon as its token arrives and never touches the frame. The result leaves as up to two new tokens, one per enabled destination, all tagged with the frame base of the instruction that fired. Incoming tokens first enter a small queue. The queue raises backpressure when it is full. When the downstream side refuses a result, the whole pipeline stalls.

Top module: `tmu_match_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `tok_ready` is 1 and both output lanes are invalid.
- R2: For a two-input operation (opcode bit 2 = 0), the first token for a given frame base and instruction produces no output. The second token for that pair fires the operation.
- R3: ALU operand A is the value that arrived on port 0 and operand B is the one from port 1, whichever of the two arrived first.
- R4: Tokens that share an instruction but have different frame bases, and whose slots differ, never pair. Interleaved activations each produce their own result.
- R5: A one-input operation (opcode bit 2 = 1) fires on a single token and leaves any operand already waiting in the frame untouched.
- R6: Lane 0 carries destination 0 and lane 1 carries destination 1, each only when that destination is enabled in the code entry. Both lanes carry the frame base of the firing token and the same result.
- R7: After a slot fires, its presence flag is clear, so the next token for that slot is stored rather than fired.
- R8: Tokens for the same slot arriving in consecutive cycles pair correctly (store then fire, and fire then store).
- R9: While an output lane is valid and `out_ready` is 0, the outputs hold and nothing advances. The unit then accepts exactly queue depth plus 3 tokens, after which `tok_ready` is 0. No token is lost when `out_ready` returns to 1.
- R10: With an idle pipeline, a token accepted at clock edge E produces its output registered at edge E+3.
- R11: The opcode encodings are:

  | Opcode | Operation |
  |---|---|
  | 0 | A+B |
  | 1 | A-B |
  | 2 | low half of A*B |
  | 3 | A&B |
  | 4 | pass A |
  | 5 | A+1 |
  | 6 | -A |
  | 7 | ~A |

  All results wrap to the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Incoming token present |
| tok_ready | output | 1 | Queue can take a token this cycle |
| tok_fp | input | FP_W | Frame base (tag) of incoming token |
| tok_ip | input | IP_W | Instruction number of incoming token |
| tok_port | input | 1 | Input side: 0 = operand A, 1 = operand B |
| tok_data | input | DATA_W | Token value |
| cw_en | input | 1 | Write one code entry |
| cw_ip | input | IP_W | Code entry being written |
| cw_op | input | 3 | Opcode |
| cw_off | input | OFF_W | Frame slot offset |
| cw_d0_en | input | 1 | Destination 0 enabled |
| cw_d0_ip | input | IP_W | Destination 0 instruction |
| cw_d0_port | input | 1 | Destination 0 port |
| cw_d1_en | input | 1 | Destination 1 enabled |
| cw_d1_ip | input | IP_W | Destination 1 instruction |
| cw_d1_port | input | 1 | Destination 1 port |
| out_ready | input | 1 | Downstream accepts the output lanes |
| o0_valid | output | 1 | Lane 0 token valid |
| o0_fp | output | FP_W | Lane 0 frame base |
| o0_ip | output | IP_W | Lane 0 instruction |
| o0_port | output | 1 | Lane 0 port |
| o0_data | output | DATA_W | Lane 0 value |
| o1_valid | output | 1 | Lane 1 token valid |
| o1_fp | output | FP_W | Lane 1 frame base |
| o1_ip | output | IP_W | Lane 1 instruction |
| o1_port | output | 1 | Lane 1 port |
| o1_data | output | DATA_W | Lane 1 value |

## Verification
The hardest case to reach is a slot being written by one token while the next token for the same slot reads it in the cycle behind. Only back-to-back tokens for one slot, with no idle cycle between them, produce this. The bench sends four such tokens in a row, so the pipeline goes through store, fire through the bypass, store straight after a clear, and fire again. A full queue is the second hard case. It appears only after the output stage has blocked and every pipeline register is occupied, so the bench holds `out_ready` low and offers a token every cycle until `tok_ready` drops.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_AND  = 3'd3,
    OP_PASS = 3'd4,
    OP_INC  = 3'd5,
    OP_NEG  = 3'd6,
    OP_NOT  = 3'd7
  } tmu_op_e;

  localparam int NUM_DEST = 2;

  function automatic logic op_is_unary(input logic [2:0] op);
    return op[2];
  endfunction
endpackage

// File: rtl/tmu_token_fifo.sv
module tmu_token_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  // R9: the producer never pushes into a full queue
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);

  // R9: occupancy grows by one on a lone push
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (cnt == $past(cnt) + (AW+1)'(1)));
endmodule

// File: rtl/tmu_code_mem.sv
module tmu_code_mem #(
  parameter int AW = 5,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tmu_frame_store.sv
module tmu_frame_store #(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic [AW-1:0] q_addr,
  output logic          q_pres,
  input  logic          val_we,
  input  logic          pres_we,
  input  logic          pres_val,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] present;

  always_ff @(posedge clk) begin
    if (val_we) mem[wr_addr] <= wr_data;
    if (rd_en)  rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)          present <= '0;
    else if (pres_we) present[wr_addr] <= pres_val;
  end

  assign q_pres = present[q_addr];

  // R7: a flag update is visible in the following cycle
  p_pres_update_r7: assert property (@(posedge clk) disable iff (rst)
    pres_we |=> (present[$past(wr_addr)] == $past(pres_val)));
endmodule

// File: rtl/tmu_alu.sv
module tmu_alu
  import tmu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [2*W-1:0] prod;

  assign prod = a * b;

  always_comb begin
    unique case (tmu_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = prod[W-1:0];
      OP_AND:  y = a & b;
      OP_PASS: y = a;
      OP_INC:  y = a + W'(1);
      OP_NEG:  y = '0 - a;
      OP_NOT:  y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/tmu_match_unit.sv
module tmu_match_unit
  import tmu_pkg::*;
#(
  parameter int FP_W    = 6,
  parameter int IP_W    = 5,
  parameter int OFF_W   = 3,
  parameter int DATA_W  = 16,
  parameter int Q_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [FP_W-1:0]   tok_fp,
  input  logic [IP_W-1:0]   tok_ip,
  input  logic              tok_port,
  input  logic [DATA_W-1:0] tok_data,
  input  logic              cw_en,
  input  logic [IP_W-1:0]   cw_ip,
  input  logic [2:0]        cw_op,
  input  logic [OFF_W-1:0]  cw_off,
  input  logic              cw_d0_en,
  input  logic [IP_W-1:0]   cw_d0_ip,
  input  logic              cw_d0_port,
  input  logic              cw_d1_en,
  input  logic [IP_W-1:0]   cw_d1_ip,
  input  logic              cw_d1_port,
  input  logic              out_ready,
  output logic              o0_valid,
  output logic [FP_W-1:0]   o0_fp,
  output logic [IP_W-1:0]   o0_ip,
  output logic              o0_port,
  output logic [DATA_W-1:0] o0_data,
  output logic              o1_valid,
  output logic [FP_W-1:0]   o1_fp,
  output logic [IP_W-1:0]   o1_ip,
  output logic              o1_port,
  output logic [DATA_W-1:0] o1_data
);
  localparam int TOK_W  = FP_W + IP_W + 1 + DATA_W;
  localparam int DST_W  = IP_W + 2;
  localparam int CE_W   = 3 + OFF_W + NUM_DEST * DST_W;
  localparam int PORT_B = DATA_W;
  localparam int IP_LSB = DATA_W + 1;
  localparam int FP_LSB = DATA_W + 1 + IP_W;

  // Stall control: the whole pipeline moves only when the output can change
  logic adv;
  assign adv = !(o0_valid || o1_valid) || out_ready;

  // Token queue
  logic             q_full, q_empty, q_push, q_pop;
  logic [TOK_W-1:0] q_din, q_dout;

  assign q_din     = {tok_fp, tok_ip, tok_port, tok_data};
  assign q_push    = tok_valid && !q_full;
  assign tok_ready = !q_full;
  assign q_pop     = adv && !q_empty;

  tmu_token_fifo #(.W(TOK_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .din(q_din), .full(q_full),
    .pop(q_pop), .dout(q_dout), .empty(q_empty)
  );

  // Instruction fetch
  logic [CE_W-1:0] cw_word, code_rd;
  assign cw_word = {cw_op, cw_off, cw_d0_en, cw_d0_ip, cw_d0_port,
                    cw_d1_en, cw_d1_ip, cw_d1_port};

  tmu_code_mem #(.AW(IP_W), .W(CE_W)) u_code (
    .clk(clk), .we(cw_en), .waddr(cw_ip), .wdata(cw_word),
    .re(q_pop), .raddr(q_dout[IP_LSB +: IP_W]), .rdata(code_rd)
  );

  // Stage 1: token with its code entry, issue frame read
  logic             s1_v;
  logic [TOK_W-1:0] s1_tok;
  logic [FP_W-1:0]  s1_fa;

  always_ff @(posedge clk) begin
    if (rst)      s1_v <= 1'b0;
    else if (adv) s1_v <= q_pop;
  end
  always_ff @(posedge clk) begin
    if (adv) s1_tok <= q_dout;
  end

  assign s1_fa = s1_tok[FP_LSB +: FP_W] + FP_W'(code_rd[CE_W-4 -: OFF_W]);

  // Stage 2: match decision
  logic              s2_v, s2_fwd;
  logic [TOK_W-1:0]  s2_tok;
  logic [CE_W-1:0]   s2_code;
  logic [FP_W-1:0]   s2_fa;
  logic [DATA_W-1:0] s2_fwd_val, slot_rd, s2_slot;
  logic [2:0]        s2_op;
  logic              s2_unary, s2_pres, s2_fire, s2_store, s2_port;
  logic [DATA_W-1:0] s2_data, alu_a, alu_b, alu_y;
  logic              val_we, pres_we;

  assign s2_op    = s2_code[CE_W-1 -: 3];
  assign s2_unary = op_is_unary(s2_op);
  assign s2_port  = s2_tok[PORT_B];
  assign s2_data  = s2_tok[DATA_W-1:0];
  assign s2_fire  = s2_v && (s2_unary || s2_pres);
  assign s2_store = s2_v && !s2_unary && !s2_pres;
  assign val_we   = adv && s2_store;
  assign pres_we  = adv && s2_v && !s2_unary;
  assign s2_slot  = s2_fwd ? s2_fwd_val : slot_rd;

  always_ff @(posedge clk) begin
    if (rst)      s2_v <= 1'b0;
    else if (adv) s2_v <= s1_v;
  end
  always_ff @(posedge clk) begin
    if (adv) begin
      s2_tok     <= s1_tok;
      s2_code    <= code_rd;
      s2_fa      <= s1_fa;
      s2_fwd     <= s2_store && (s2_fa == s1_fa);
      s2_fwd_val <= s2_data;
    end
  end

  tmu_frame_store #(.AW(FP_W), .W(DATA_W)) u_frame (
    .clk(clk), .rst(rst),
    .rd_en(adv), .rd_addr(s1_fa), .rd_data(slot_rd),
    .q_addr(s2_fa), .q_pres(s2_pres),
    .val_we(val_we), .pres_we(pres_we), .pres_val(!s2_pres),
    .wr_addr(s2_fa), .wr_data(s2_data)
  );

  always_comb begin
    if (s2_unary) begin
      alu_a = s2_data;
      alu_b = '0;
    end else if (s2_port) begin
      alu_a = s2_slot;
      alu_b = s2_data;
    end else begin
      alu_a = s2_data;
      alu_b = s2_slot;
    end
  end

  tmu_alu #(.W(DATA_W)) u_alu (.op(s2_op), .a(alu_a), .b(alu_b), .y(alu_y));

  // Destination decode and output lanes
  logic [NUM_DEST-1:0]            dst_en, lane_v, lane_port;
  logic [NUM_DEST-1:0][IP_W-1:0]  dst_ip, lane_ip;
  logic [NUM_DEST-1:0]            dst_port;
  logic [NUM_DEST-1:0][FP_W-1:0]  lane_fp;
  logic [NUM_DEST-1:0][DATA_W-1:0] lane_data;

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_dst
    localparam int LSB = (NUM_DEST - 1 - g) * DST_W;
    assign dst_en[g]   = s2_code[LSB + DST_W - 1];
    assign dst_ip[g]   = s2_code[LSB + 1 +: IP_W];
    assign dst_port[g] = s2_code[LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_v <= '0;
    end else if (adv) begin
      for (int i = 0; i < NUM_DEST; i++) lane_v[i] <= s2_fire && dst_en[i];
    end
  end
  always_ff @(posedge clk) begin
    if (adv) begin
      for (int i = 0; i < NUM_DEST; i++) begin
        lane_ip[i]   <= dst_ip[i];
        lane_port[i] <= dst_port[i];
        lane_fp[i]   <= s2_tok[FP_LSB +: FP_W];
        lane_data[i] <= alu_y;
      end
    end
  end

  assign o0_valid = lane_v[0];
  assign o0_fp    = lane_fp[0];
  assign o0_ip    = lane_ip[0];
  assign o0_port  = lane_port[0];
  assign o0_data  = lane_data[0];
  assign o1_valid = lane_v[1];
  assign o1_fp    = lane_fp[1];
  assign o1_ip    = lane_ip[1];
  assign o1_port  = lane_port[1];
  assign o1_data  = lane_data[1];

  // R9: a refused output holds its contents
  p_hold_out_r9: assert property (@(posedge clk) disable iff (rst)
    (o0_valid && !out_ready) |=> (o0_valid && $stable(o0_data) && $stable(o0_ip)));

  // R6: both lanes of one firing carry the same tag and result
  p_lanes_agree_r6: assert property (@(posedge clk) disable iff (rst)
    (o0_valid && o1_valid) |-> (o0_fp == o1_fp && o0_data == o1_data));

  // R6: output tag is the tag of the firing token
  p_fp_inherit_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && s2_fire) |=> (o0_fp == $past(s2_tok[FP_LSB +: FP_W])));

  // R5: one-input operations never write the frame
  p_unary_no_frame_r5: assert property (@(posedge clk) disable iff (rst)
    (s2_v && s2_unary) |-> (!val_we && !pres_we));
endmodule

// File: tb/test_tmu_match_unit.sv
module test_tmu_match_unit;
  localparam int CLK_PERIOD = 10;
  localparam int FP_W = 6, IP_W = 5, OFF_W = 3, DATA_W = 16, Q_DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic tok_valid = 1'b0, tok_port = 1'b0;
  logic [FP_W-1:0] tok_fp = '0;
  logic [IP_W-1:0] tok_ip = '0;
  logic [DATA_W-1:0] tok_data = '0;
  logic tok_ready;
  logic cw_en = 1'b0, cw_d0_en = 1'b0, cw_d0_port = 1'b0, cw_d1_en = 1'b0, cw_d1_port = 1'b0;
  logic [IP_W-1:0] cw_ip = '0, cw_d0_ip = '0, cw_d1_ip = '0;
  logic [2:0] cw_op = '0;
  logic [OFF_W-1:0] cw_off = '0;
  logic out_ready = 1'b1;
  logic o0_valid, o0_port, o1_valid, o1_port;
  logic [FP_W-1:0] o0_fp, o1_fp;
  logic [IP_W-1:0] o0_ip, o1_ip;
  logic [DATA_W-1:0] o0_data, o1_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // log of accepted output tokens
  int lg_n = 0;
  int lg_lane [256];
  int lg_fp [256];
  int lg_ip [256];
  int lg_port [256];
  int lg_data [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmu_match_unit #(.FP_W(FP_W), .IP_W(IP_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
                   .Q_DEPTH(Q_DEPTH)) i_tmu_match_unit (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_fp(tok_fp), .tok_ip(tok_ip), .tok_port(tok_port), .tok_data(tok_data),
    .cw_en(cw_en), .cw_ip(cw_ip), .cw_op(cw_op), .cw_off(cw_off),
    .cw_d0_en(cw_d0_en), .cw_d0_ip(cw_d0_ip), .cw_d0_port(cw_d0_port),
    .cw_d1_en(cw_d1_en), .cw_d1_ip(cw_d1_ip), .cw_d1_port(cw_d1_port),
    .out_ready(out_ready),
    .o0_valid(o0_valid), .o0_fp(o0_fp), .o0_ip(o0_ip), .o0_port(o0_port), .o0_data(o0_data),
    .o1_valid(o1_valid), .o1_fp(o1_fp), .o1_ip(o1_ip), .o1_port(o1_port), .o1_data(o1_data)
  );

  always @(negedge clk) begin
    if (!rst && out_ready && lg_n < 254) begin
      if (o0_valid) begin
        lg_lane[lg_n] = 0; lg_fp[lg_n] = int'(o0_fp); lg_ip[lg_n] = int'(o0_ip);
        lg_port[lg_n] = int'(o0_port); lg_data[lg_n] = int'(o0_data); lg_n++;
      end
      if (o1_valid) begin
        lg_lane[lg_n] = 1; lg_fp[lg_n] = int'(o1_fp); lg_ip[lg_n] = int'(o1_ip);
        lg_port[lg_n] = int'(o1_port); lg_data[lg_n] = int'(o1_data); lg_n++;
      end
    end
  end

  function automatic int alu_ref(input int op, input int a, input int b);
    int r;
    case (op)
      0: r = a + b;
      1: r = a - b;
      2: r = a * b;
      3: r = a & b;
      4: r = a;
      5: r = a + 1;
      6: r = -a;
      default: r = ~a;
    endcase
    return r & 16'hFFFF;
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic expect_tok(input string req, input int idx, input int lane, input int fp,
                            input int ip, input int port, input int data);
    if (idx >= lg_n) begin
      check_eq(req, "output token present", 0, 1);
    end else begin
      check_eq(req, "lane", lg_lane[idx], lane);
      check_eq(req, "fp", lg_fp[idx], fp);
      check_eq(req, "ip", lg_ip[idx], ip);
      check_eq(req, "port", lg_port[idx], port);
      check_eq(req, "data", lg_data[idx], data);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_code(input int ip, input int op, input int off,
                           input bit e0, input int ip0, input bit p0,
                           input bit e1, input int ip1, input bit p1);
    cw_en = 1'b1; cw_ip = IP_W'(ip); cw_op = 3'(op); cw_off = OFF_W'(off);
    cw_d0_en = e0; cw_d0_ip = IP_W'(ip0); cw_d0_port = p0;
    cw_d1_en = e1; cw_d1_ip = IP_W'(ip1); cw_d1_port = p1;
    @(posedge clk); #1;
    cw_en = 1'b0;
  endtask

  task automatic send(input int fp, input int ip, input bit port, input int data);
    tok_valid = 1'b1; tok_fp = FP_W'(fp); tok_ip = IP_W'(ip);
    tok_port = port; tok_data = DATA_W'(data);
    forever begin
      @(negedge clk);
      if (tok_ready) break;
    end
    @(posedge clk); #1;
    tok_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R1", "tok_ready in reset", int'(tok_ready), 1);
    check_eq("R1", "o0_valid in reset", int'(o0_valid), 0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "tok_ready after reset", int'(tok_ready), 1);
    check_eq("R1", "o1_valid after reset", int'(o1_valid), 0);
  endtask

  task automatic t_pair_basic();
    int b = lg_n;
    send(8, 1, 1'b0, 5);
    idle(8);
    check_eq("R2", "no output after first operand", lg_n - b, 0);
    send(8, 1, 1'b1, 7);
    idle(8);
    check_eq("R2", "tokens after pair", lg_n - b, 2);
    expect_tok("R2", b, 0, 8, 10, 0, 12);
    expect_tok("R6", b + 1, 1, 8, 11, 1, 12);
  endtask

  task automatic t_port_order();
    int b = lg_n;
    send(16, 2, 1'b1, 3);
    send(16, 2, 1'b0, 10);
    idle(8);
    send(16, 2, 1'b0, 10);
    send(16, 2, 1'b1, 3);
    idle(8);
    check_eq("R3", "token count", lg_n - b, 2);
    expect_tok("R3", b, 0, 16, 12, 0, alu_ref(1, 10, 3));
    expect_tok("R3", b + 1, 0, 16, 12, 0, alu_ref(1, 10, 3));
  endtask

  task automatic t_interleave();
    int b = lg_n;
    send(20, 1, 1'b0, 1);
    send(30, 1, 1'b0, 100);
    send(20, 1, 1'b1, 2);
    send(30, 1, 1'b1, 200);
    idle(8);
    check_eq("R4", "token count", lg_n - b, 4);
    expect_tok("R4", b, 0, 20, 10, 0, 3);
    expect_tok("R4", b + 2, 0, 30, 10, 0, 300);
  endtask

  task automatic t_unary();
    int b = lg_n;
    send(40, 1, 1'b0, 9);
    send(40, 4, 1'b0, 0);
    idle(8);
    check_eq("R5", "single token fires alone", lg_n - b, 1);
    expect_tok("R5", b, 0, 40, 14, 0, 1);
    send(40, 1, 1'b1, 1);
    idle(8);
    check_eq("R5", "pending operand kept", lg_n - b, 3);
    expect_tok("R5", b + 1, 0, 40, 10, 0, 10);
  endtask

  task automatic t_reuse();
    int b = lg_n;
    send(50, 1, 1'b0, 1);
    send(50, 1, 1'b1, 2);
    idle(6);
    send(50, 1, 1'b0, 4);
    idle(8);
    check_eq("R7", "third token stored", lg_n - b, 2);
    send(50, 1, 1'b1, 8);
    idle(8);
    check_eq("R7", "slot reused count", lg_n - b, 4);
    expect_tok("R7", b + 2, 0, 50, 10, 0, 12);
  endtask

  task automatic t_back_to_back();
    int b = lg_n;
    send(60, 3, 1'b0, 6);
    send(60, 3, 1'b1, 7);
    send(60, 1, 1'b0, 1);
    send(60, 1, 1'b1, 2);
    send(60, 1, 1'b0, 3);
    send(60, 1, 1'b1, 4);
    idle(8);
    check_eq("R8", "token count", lg_n - b, 5);
    expect_tok("R8", b, 0, 60, 13, 1, 42);
    expect_tok("R8", b + 1, 0, 60, 10, 0, 3);
    expect_tok("R8", b + 3, 0, 60, 10, 0, 7);
  endtask

  task automatic t_alu_ops();
    int b = lg_n;
    send(7, 5, 1'b0, 16'h00F0);
    send(10, 6, 1'b0, 16'h0F0F);
    send(10, 6, 1'b1, 16'h00FF);
    send(1, 7, 1'b0, 5);
    send(2, 8, 1'b0, 16'h1234);
    send(0, 3, 1'b1, 300);
    send(0, 3, 1'b0, 300);
    idle(8);
    check_eq("R11", "token count", lg_n - b, 6);
    expect_tok("R11", b, 0, 7, 15, 0, alu_ref(7, 16'h00F0, 0));
    expect_tok("R6", b + 1, 1, 7, 16, 1, alu_ref(7, 16'h00F0, 0));
    expect_tok("R11", b + 2, 0, 10, 17, 0, alu_ref(3, 16'h0F0F, 16'h00FF));
    expect_tok("R11", b + 3, 0, 1, 18, 1, alu_ref(6, 5, 0));
    expect_tok("R11", b + 4, 0, 2, 19, 0, alu_ref(4, 16'h1234, 0));
    expect_tok("R11", b + 5, 0, 0, 13, 1, alu_ref(2, 300, 300));
  endtask

  task automatic t_latency();
    tok_valid = 1'b1; tok_fp = 6'd5; tok_ip = 5'd4; tok_port = 1'b0; tok_data = 16'd41;
    @(negedge clk);
    check_eq("R10", "ready at offer", int'(tok_ready), 1);
    @(posedge clk); #1;
    tok_valid = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check_eq("R10", $sformatf("o0_valid at edge +%0d", k - 1), int'(o0_valid), 0);
    end
    @(negedge clk);
    check_eq("R10", "o0_valid at edge +3", int'(o0_valid), 1);
    check_eq("R10", "o0_data at edge +3", int'(o0_data), 42);
    idle(2);
  endtask

  task automatic t_backpressure();
    int b = lg_n;
    int acc = 0;
    out_ready = 1'b0;
    for (int k = 0; k < 14; k++) begin
      tok_valid = 1'b1; tok_fp = 6'd3; tok_ip = 5'd4; tok_port = 1'b0;
      tok_data = DATA_W'(100 + acc);
      @(negedge clk);
      if (tok_ready) acc++;
      @(posedge clk); #1;
    end
    tok_valid = 1'b0;
    @(negedge clk);
    check_eq("R9", "tokens accepted while stalled", acc, Q_DEPTH + 3);
    check_eq("R9", "tok_ready while full", int'(tok_ready), 0);
    check_eq("R9", "output held valid", int'(o0_valid), 1);
    check_eq("R9", "held data", int'(o0_data), 101);
    check_eq("R9", "nothing taken while stalled", lg_n - b, 0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    idle(16);
    check_eq("R9", "all released", lg_n - b, Q_DEPTH + 3);
    for (int k = 0; k < Q_DEPTH + 3; k++) expect_tok("R9", b + k, 0, 3, 14, 0, 101 + k);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    load_code(1, 0, 0, 1'b1, 10, 1'b0, 1'b1, 11, 1'b1);
    load_code(2, 1, 1, 1'b1, 12, 1'b0, 1'b0, 0, 1'b0);
    load_code(3, 2, 2, 1'b1, 13, 1'b1, 1'b0, 0, 1'b0);
    load_code(4, 5, 0, 1'b1, 14, 1'b0, 1'b0, 0, 1'b0);
    load_code(5, 7, 0, 1'b1, 15, 1'b0, 1'b1, 16, 1'b1);
    load_code(6, 3, 3, 1'b1, 17, 1'b0, 1'b0, 0, 1'b0);
    load_code(7, 6, 0, 1'b1, 18, 1'b1, 1'b0, 0, 1'b0);
    load_code(8, 4, 0, 1'b1, 19, 1'b0, 1'b0, 0, 1'b0);
    idle(2);
    t_pair_basic();
    t_port_order();
    t_interleave();
    t_unary();
    t_reuse();
    t_back_to_back();
    t_alu_ops();
    t_latency();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule